// File: doc/BRIEF.md
# DRAM Bring-Up and Training Sequencer

This block walks a DRAM interface from reset to a usable state. Software writes one control word. That word holds a mask of training steps, a memory type and a start bit. The sequencer then runs a fixed series of phases: it sets up the controller and PHY registers, initialises the DRAM, and then runs the training steps that are both enabled and valid for the chosen memory type. When the sequence is over it raises a done flag, and it also raises a ready indication if nothing failed.

The sequencer does not do any phase itself. For each phase it gives a one-cycle launch pulse and an operation code to an external engine, then waits for that engine's done pulse and its error bit. If a step fails, its error is recorded and the sequence goes on. Software polls a status word to see busy, done, the per-operation error bits, a summary error bit and a configuration-error bit.

Top module: `dram_init_seq`

## Requirements
- R1: Operation codes are 0 controller/PHY setup, 1 DRAM initialisation, 2 impedance calibration, 3 write leveling, 4 DQS gate training, 5 write DQS-to-DQ training, 6 data eye training, 7 VREF training. Codes 0 and 1 always run, and operations are launched in strictly ascending code order starting with 0.
- R2: A write to address 0 loads the control word: bits [6:0] enable mask (bit 0 impedance, 1 write leveling, 2 DQS gate, 3 DQS-to-DQ, 4 data eye, 5 VREF, 6 command/address training), bits [8:7] memory type (00 LPDDR4, 01 DDR4, 10 DDR3L, 11 reserved), and bit 9 start. Reading address 0 returns mask and type with bit 9 zero. A write with bit 9 clear launches nothing. Reading address 1 returns status: bit 0 busy, 1 done, 2 error summary, 3 config error, 4 ready, bits [15:8] the error bit of each operation code.
- R3: Impedance calibration, write leveling, DQS gate and data eye training run for all three valid memory types when enabled.
- R4: DQS-to-DQ training runs only for LPDDR4. VREF training runs only for LPDDR4 and DDR4, never for DDR3L.
- R5: Command/address training is never launched, whatever its enable bit and type.
- R6: A step that is disabled or not valid takes no handshake. The launch pulse is one cycle long. The first launch appears in the cycle after the accepted start write, and each later launch in the cycle after the previous step's done.
- R7: A step's error bit is sticky for the rest of the run and does not stop the sequence. The summary bit is the OR of all operation error bits.
- R8: Done rises when the last operation completes, and busy falls then. Ready is high only when done is set with no operation error and no config error.
- R9: While busy, writes to address 0 are ignored, including start, mask and type.
- R10: An accepted start clears done, config error and all operation error bits.
- R11: An accepted start with reserved type 11 launches nothing and sets done and config error in the next cycle.
- R12: After reset the status word is zero and no launch pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control) |
| wr_data | input | 10 | Write data |
| rd_addr | input | 1 | Read address (0 control, 1 status) |
| rd_data | output | 16 | Read data, combinational |
| eng_start | output | 1 | One-cycle launch pulse to the step engine |
| eng_op | output | 3 | Operation code being run |
| eng_done | input | 1 | Step engine completion pulse |
| eng_err | input | 1 | Step engine error, valid with eng_done |
| phy_ready | output | 1 | Interface ready, no failures |

## Verification
The assertions assume that the engine gives exactly one done pulse for each launch, and only while the sequencer is waiting for it. They also assume that eng_err is read only alongside eng_done. The bench's engine model keeps to these rules. It counts a programmable latency from each launch it observes and then returns a single done pulse, and it never returns done without a launch. Register writes come at arbitrary times, including in the middle of a run, because a write is a legal input whenever it happens.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int NUM_OPS   = 8;
    localparam int OP_W      = $clog2(NUM_OPS);
    localparam int NUM_TRAIN = 7;
    localparam int FIXED_OPS = 2;
    localparam int WDATA_W   = 10;
    localparam int RDATA_W   = 16;
    localparam int TYPE_LSB  = 7;
    localparam int START_BIT = 9;
    localparam int ERR_LSB   = 8;

    typedef enum logic [1:0] {
        MT_LP4 = 2'b00,
        MT_D4  = 2'b01,
        MT_D3L = 2'b10,
        MT_RSV = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [OP_W-1:0]     op;
        logic [NUM_OPS-1:0]  err;
    } fsm_regs_t;

    typedef struct packed {
        logic [NUM_TRAIN-1:0] en;
        logic [1:0]           mt;
        logic                 done;
        logic                 cfg;
    } top_regs_t;

    // step index k: 0 imp, 1 wl, 2 gate, 3 dqs2dq, 4 eye, 5 vref
    function automatic logic type_allows(input logic [1:0] mt, input int k);
        case (mt)
            MT_LP4:  type_allows = 1'b1;
            MT_D4:   type_allows = (k != 3);
            MT_D3L:  type_allows = (k != 3) && (k != 5);
            default: type_allows = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dis_elig.sv
module dis_elig
    import dis_pkg::*;
(
    input  logic [1:0]           mem_type,
    input  logic [NUM_OPS-3:0]   train_en,
    output logic [NUM_OPS-1:0]   run_mask
);
    assign run_mask[FIXED_OPS-1:0] = '1;

    for (genvar k = 0; k < NUM_OPS - FIXED_OPS; k++) begin : g_train
        assign run_mask[k+FIXED_OPS] = train_en[k] & type_allows(mem_type, k);
    end
endmodule

// File: rtl/dis_pick.sv
module dis_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] cur,
    output logic         found,
    output logic [W-1:0] nxt
);
    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i > int'(cur))) begin
                found = 1'b1;
                nxt   = i[W-1:0];
            end
        end
    end
endmodule

// File: rtl/dis_fsm.sv
module dis_fsm
    import dis_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               go,
    input  logic [NUM_OPS-1:0] run_mask,
    input  logic               eng_done,
    input  logic               eng_err,
    output logic               eng_start,
    output logic [OP_W-1:0]    eng_op,
    output logic               busy,
    output logic [NUM_OPS-1:0] err,
    output logic               fin
);
    fsm_regs_t r_q, r_d;
    logic            nxt_found;
    logic [OP_W-1:0] nxt_op;

    dis_pick #(.N(NUM_OPS), .W(OP_W)) u_pick (
        .mask  (run_mask),
        .cur   (r_q.op),
        .found (nxt_found),
        .nxt   (nxt_op)
    );

    always_comb begin
        r_d = r_q;
        fin = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (clr) r_d.err = '0;
                if (go) begin
                    r_d.st = ST_LAUNCH;
                    r_d.op = '0;
                end
            end
            ST_LAUNCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (eng_done) begin
                    r_d.err[r_q.op] = r_q.err[r_q.op] | eng_err;
                    if (nxt_found) begin
                        r_d.op = nxt_op;
                        r_d.st = ST_LAUNCH;
                    end else begin
                        r_d.st = ST_IDLE;
                        fin    = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.op  <= '0;
            r_q.err <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_start = (r_q.st == ST_LAUNCH);
    assign eng_op    = r_q.op;
    assign busy      = (r_q.st != ST_IDLE);
    assign err       = r_q.err;

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    p_first_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (eng_op == '0));

    p_op_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && eng_done && nxt_found) |=> (eng_op > $past(eng_op)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((err & $past(err)) == $past(err)));
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dis_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               rd_addr,
    output logic [RDATA_W-1:0] rd_data,
    output logic               eng_start,
    output logic [OP_W-1:0]    eng_op,
    input  logic               eng_done,
    input  logic               eng_err,
    output logic               phy_ready
);
    top_regs_t q, d;
    logic               busy, fin, acc, start_acc, rsv, go;
    logic [NUM_OPS-1:0] run_mask, op_err;
    logic [1:0]         wr_type;

    assign wr_type   = wr_data[TYPE_LSB +: 2];
    assign acc       = wr_en && !wr_addr && !busy;
    assign start_acc = acc && wr_data[START_BIT];
    assign rsv       = (wr_type == MT_RSV);
    assign go        = start_acc && !rsv;

    dis_elig u_elig (
        .mem_type (q.mt),
        .train_en (q.en[NUM_OPS-3:0]),
        .run_mask (run_mask)
    );

    dis_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_acc),
        .go        (go),
        .run_mask  (run_mask),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .eng_start (eng_start),
        .eng_op    (eng_op),
        .busy      (busy),
        .err       (op_err),
        .fin       (fin)
    );

    always_comb begin
        d = q;
        if (acc) begin
            d.en = wr_data[NUM_TRAIN-1:0];
            d.mt = wr_type;
        end
        if (start_acc) begin
            d.done = rsv;
            d.cfg  = rsv;
        end
        if (fin) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.en   <= '0;
            q.mt   <= '0;
            q.done <= 1'b0;
            q.cfg  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign phy_ready = q.done && !q.cfg && !(|op_err);

    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[NUM_TRAIN-1:0]   = q.en;
            rd_data[TYPE_LSB +: 2]   = q.mt;
        end else begin
            rd_data[0]                 = busy;
            rd_data[1]                 = q.done;
            rd_data[2]                 = |op_err;
            rd_data[3]                 = q.cfg;
            rd_data[4]                 = phy_ready;
            rd_data[ERR_LSB +: NUM_OPS] = op_err;
        end
    end

    p_launch_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> run_mask[eng_op]);

    p_reserved_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && rsv) |=> (q.done && q.cfg && !busy));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !busy);

    p_busy_holds_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q.en) && $stable(q.mt)));
endmodule

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic        wr_addr = 0;
    logic [9:0]  wr_data = '0;
    logic        rd_addr = 1;
    logic [15:0] rd_data;
    logic        eng_start;
    logic [2:0]  eng_op;
    logic        eng_done = 0;
    logic        eng_err = 0;
    logic        phy_ready;

    int checks = 0;
    int failures = 0;
    int exp_ops[$];
    bit errplan[8];
    int lat = 1;
    int cnt = 0;
    int cur_op = 0;
    int launched = 0;

    always #2.5 clk = ~clk;

    dram_init_seq u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit allowed(input int ty, input int k);
        if (k == 6) return 0;
        if (ty == 0) return 1;
        if (ty == 1) return k != 3;
        if (ty == 2) return (k != 3) && (k != 5);
        return 0;
    endfunction

    // engine model and per-clock sequence reference
    initial begin
        forever begin
            @(negedge clk);
            if (eng_done) begin
                eng_done = 0;
                eng_err = 0;
                if (exp_ops.size() > 0)
                    chk(eng_start == 1, "R6 next launch follows done", eng_start, 1);
            end
            if (eng_start) begin
                launched++;
                if (exp_ops.size() == 0) begin
                    chk(0, "R5 unexpected launch", eng_op, 0);
                end else begin
                    int e;
                    e = exp_ops.pop_front();
                    chk(eng_op == e, "R1 launch order", eng_op, e);
                end
                cur_op = eng_op;
                cnt = lat;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    eng_done = 1;
                    eng_err = errplan[cur_op];
                end
            end
        end
    end

    task automatic wr(input bit a, input logic [9:0] v);
        @(negedge clk);
        wr_addr = a;
        wr_data = v;
        wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic launch(input int mask, input int ty, input int errs, input int l);
        exp_ops.delete();
        lat = l;
        for (int i = 0; i < 8; i++) errplan[i] = errs[i];
        exp_ops.push_back(0);
        exp_ops.push_back(1);
        for (int k = 0; k < 7; k++)
            if (mask[k] && allowed(ty, k)) exp_ops.push_back(k + 2);
        wr(0, 10'(mask | (ty << 7) | (1 << 9)));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            rd_addr = 1;
            #1;
            if (rd_data[0] == 0) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_check(input int errs, input string tag, input int opmask);
        int exp_st;
        int e;
        wait_idle();
        rd_addr = 1;
        #1;
        e = errs & opmask;
        exp_st = 2 | ((e != 0) ? 4 : 0) | ((e == 0) ? 16 : 0) | (e << 8);
        chk(exp_ops.size() == 0, {tag, " all expected ops launched"}, exp_ops.size(), 0);
        chk(rd_data == 16'(exp_st), {tag, " final status"}, rd_data, exp_st);
        chk(phy_ready == (e == 0), "R8 ready pin", phy_ready, e == 0);
    endtask

    function automatic int opmask_of(input int mask, input int ty);
        int m;
        m = 3;
        for (int k = 0; k < 7; k++) if (mask[k] && allowed(ty, k)) m |= 1 << (k + 2);
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_addr = 1;
        #1;
        chk(rd_data == 0, "R12 reset status", rd_data, 0);
        chk(eng_start == 0, "R12 no launch after reset", eng_start, 0);

        // R2: write without start launches nothing, readback of fields
        n = launched;
        wr(0, 10'h0AB);
        repeat (4) @(negedge clk);
        rd_addr = 0;
        #1;
        chk(rd_data == 16'h00AB, "R2 control readback", rd_data, 16'h00AB);
        chk(launched == n, "R2 no start, no launch", launched, n);

        // R1 R3 R4 R5: LPDDR4 all enabled, CA skipped
        launch(7'h7F, 0, 0, 1);
        finish_check(0, "R4 LPDDR4 full", opmask_of(7'h7F, 0));

        // R4: DDR4 drops DQS-to-DQ
        launch(7'h7F, 1, 0, 2);
        finish_check(0, "R4 DDR4 full", opmask_of(7'h7F, 1));

        // R3 R7: DDR3L with a failing write leveling step, sequence continues
        launch(7'h7F, 2, 8'h08, 3);
        finish_check(8'h08, "R7 DDR3L sticky error", opmask_of(7'h7F, 2));

        // R5: only CA enabled -> only fixed phases
        launch(7'h40, 0, 0, 1);
        finish_check(0, "R5 CA only", opmask_of(7'h40, 0));

        // R7 R8: errors in setup and data eye, sparse mask
        launch(7'h15, 0, 8'h41, 2);
        finish_check(8'h41, "R7 multiple errors", opmask_of(7'h15, 0));

        // R10: clean run after failing one clears error bits
        launch(7'h01, 1, 0, 1);
        finish_check(0, "R10 errors cleared by start", opmask_of(7'h01, 1));

        // R9: writes while busy are ignored
        launch(7'h01, 1, 0, 6);
        @(negedge clk);
        wr(0, 10'h3FF);
        finish_check(0, "R9 start while busy ignored", opmask_of(7'h01, 1));
        rd_addr = 0;
        #1;
        chk(rd_data == 16'h0081, "R9 fields unchanged by busy write", rd_data, 16'h0081);

        // R11 R10: reserved type after an errored run
        launch(7'h01, 2, 8'h01, 1);
        finish_check(8'h01, "R7 setup error", opmask_of(7'h01, 2));
        n = launched;
        exp_ops.delete();
        @(negedge clk);
        wr_addr = 0;
        wr_data = 10'h3FF;
        wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        rd_addr = 1;
        #1;
        chk(rd_data == 16'h000A, "R11 reserved type done+cfg, R10 errors cleared", rd_data, 16'h000A);
        chk(phy_ready == 0, "R11 not ready on config error", phy_ready, 0);
        repeat (5) @(negedge clk);
        chk(launched == n, "R11 no launch for reserved type", launched, n);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule